// File: doc/BRIEF.md
# Gated Interval Timer

A 16-bit up-counter with a programmable period. It has three counting sources, chosen by a mode input. In the first, it counts system clock cycles. In the second, it counts rising edges on an external pin. In the third, it accumulates system clock cycles only while that pin is held high, which measures how long the pin stays high. The pin always passes through a two-stage synchronizer, and its edges are found on the synchronized copy.

When the counter advances while it already equals the period value, it returns to zero and raises a sticky event flag. In the gated mode, the flag is also raised when the synchronized pin falls. Software can then read the accumulated high time. The flag stays set until the clear input is pulsed. A low enable freezes both the count and every event source.

Top module: `gtimer`

## Requirements
- R1: While reset (active low, asynchronous) is asserted, and after it is released, the count is 0 and the flag is 0.
- R2: In mode 2'b00 with enable high, the count advances by one on every clock edge.
- R3: In mode 2'b01 with enable high, the count advances by one for each rising edge of the pin. A rise first sampled high at clock edge k changes the count at edge k+2.
- R4: In mode 2'b10 with enable high, the count advances on each clock edge while the synchronized pin is high, two edges behind the pin, and holds while it is low.
- R5: An advance taken while the count equals the period sets the count to 0 and sets the flag in the same edge.
- R6: In mode 2'b10 with enable high, a falling edge of the pin sets the flag two edges after the first low sample. The accumulated count is left unchanged.
- R7: While enable is low, the count holds and no source sets the flag.
- R8: The flag stays set until the clear input is high at a clock edge. If a set and a clear coincide, the set wins.
- R9: Mode 2'b11 holds the count and never sets the flag.
- R10: With the period at 0, the count stays 0 and every advance sets the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Counting enable |
| mode | input | 2 | 00 internal, 01 pin edges, 10 gated, 11 idle |
| tpin | input | 1 | External clock or gate pin |
| period | input | 16 | Wrap value |
| irq_clr | input | 1 | Clears the event flag |
| count | output | 16 | Current count |
| irq | output | 1 | Sticky event flag |

## Verification
The counter is driven with steady internal counting, with pin pulse trains in the edge mode, and with long and short high windows in the gated mode. Together these separate counting on every clock, counting on each rise, and counting while the pin is high, and they expose any error in the two-edge synchronizer delay. A random mix changes the mode, enable, period and clear while the pin toggles, so that wraps near small periods, falls of the gate and set-against-clear collisions all occur. Directed cases pin down a period of zero, a freeze while enable is low, and a fall that raises the flag without touching the accumulated time.

// File: rtl/gtimer.sv
module gtimer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [1:0]   mode,
  input  logic         tpin,
  input  logic [W-1:0] period,
  input  logic         irq_clr,
  output logic [W-1:0] count,
  output logic         irq
);
  logic [2:0] pin_q;
  logic       gate, rise, fall, tick, wrap, irq_set;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pin_q <= '0;
    else        pin_q <= {pin_q[1:0], tpin};

  assign gate = pin_q[1];
  assign rise = pin_q[1] & ~pin_q[2];
  assign fall = ~pin_q[1] & pin_q[2];

  always_comb begin
    case (mode)
      2'b00:   tick = en;
      2'b01:   tick = en & rise;
      2'b10:   tick = en & gate;
      default: tick = 1'b0;
    endcase
  end

  assign wrap    = tick && (count == period);
  assign irq_set = wrap || (en && mode == 2'b10 && fall);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    count <= '0;
    else if (wrap) count <= '0;
    else if (tick) count <= count + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       irq <= 1'b0;
    else if (irq_set) irq <= 1'b1;
    else if (irq_clr) irq <= 1'b0;
endmodule

module gtimer_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         en,
  input logic [1:0]   mode,
  input logic [W-1:0] period,
  input logic         irq_clr,
  input logic [W-1:0] count,
  input logic         irq,
  input logic         gate_s
);
  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(count)); // R7
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq); // R8
  AST_INT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mode == 2'b00 && count != period) |=> (count == $past(count) + 1'b1)); // R2
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mode == 2'b00 && count == period) |=> (count == '0 && irq)); // R5
  AST_GATE_LOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10 && !gate_s) |=> $stable(count)); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b11) |=> $stable(count)); // R9
endmodule

bind gtimer gtimer_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .period(period),
  .irq_clr(irq_clr), .count(count), .irq(irq), .gate_s(gate)
);

// File: tb/test_gtimer.sv
module test_gtimer;
  localparam int W = 16;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         en = 1'b0;
  logic [1:0]   mode = 2'b00;
  logic         tpin = 1'b0;
  logic [W-1:0] period = '0;
  logic         irq_clr = 1'b0;
  logic [W-1:0] count;
  logic         irq;

  int compared = 0, mismatched = 0;
  bit done = 0;

  gtimer #(.W(W)) i_gtimer (.*);

  always #5 clk = ~clk;

  // reference model built from the requirements
  logic [2:0]   m_pin;
  logic [W-1:0] m_cnt;
  logic         m_irq;

  function automatic bit adv(input logic e, input logic [1:0] md, input logic [2:0] p);
    case (md)
      2'b00:   return e;
      2'b01:   return e && p[1] && !p[2];
      2'b10:   return e && p[1];
      default: return 1'b0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pin <= '0; m_cnt <= '0; m_irq <= 1'b0;
    end else begin
      bit a, s;
      a = adv(en, mode, m_pin);
      s = (a && m_cnt == period) || (en && mode == 2'b10 && !m_pin[1] && m_pin[2]);
      m_pin <= {m_pin[1:0], tpin};
      if (a) m_cnt <= (m_cnt == period) ? '0 : m_cnt + 1'b1;
      if (s) m_irq <= 1'b1;
      else if (irq_clr) m_irq <= 1'b0;
    end
  end

  function automatic string tag_now();
    if (!en) return "R7";
    case (mode)
      2'b00: return "R2";
      2'b01: return "R3";
      2'b10: return "R4";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
    chk(tag_now(), count, m_cnt);
    chk(m_irq ? "R5" : "R8", {{(W-1){1'b0}}, irq}, {{(W-1){1'b0}}, m_irq});
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; en = 0; tpin = 0; irq_clr = 0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  initial begin
    void'($urandom(32'h5eed1234));
    @(negedge clk); @(negedge clk);
    chk("R1", count, 0); chk("R1", {{(W-1){1'b0}}, irq}, 0);
    rst_n = 1'b1;
    step();
    chk("R1", count, 0); chk("R1", {{(W-1){1'b0}}, irq}, 0);

    // R5 wrap on internal clock
    mode = 2'b00; period = 16'd3; en = 1;
    repeat (4) step();
    chk("R5", count, 0); chk("R5", {{(W-1){1'b0}}, irq}, 1);

    // R8 clear, then set beats clear
    en = 0; irq_clr = 1; step(); irq_clr = 0;
    chk("R8", {{(W-1){1'b0}}, irq}, 0);
    step(); step();
    chk("R7", count, 0);
    period = 16'd0; en = 1; irq_clr = 1;
    step(); step();
    chk("R10", count, 0); chk("R8", {{(W-1){1'b0}}, irq}, 1);
    irq_clr = 0;

    // R3 four pulses on the pin
    do_reset(); mode = 2'b01; period = 16'd100; en = 1;
    for (int i = 0; i < 4; i++) begin
      tpin = 1; step(); step(); tpin = 0; step(); step();
    end
    repeat (3) step();
    chk("R3", count, 4);

    // R6 gated window of 5 cycles then a fall
    do_reset(); mode = 2'b10; period = 16'd100; en = 1;
    step();
    tpin = 1; repeat (5) step(); tpin = 0;
    repeat (4) step();
    chk("R6", count, 5); chk("R6", {{(W-1){1'b0}}, irq}, 1);

    // R9 idle mode
    irq_clr = 1; step(); irq_clr = 0; mode = 2'b11;
    tpin = 1; repeat (3) step(); tpin = 0; repeat (4) step();
    chk("R9", count, 5); chk("R9", {{(W-1){1'b0}}, irq}, 0);

    // random mix
    do_reset();
    for (int n = 0; n < 6000; n++) begin
      step();
      if ($urandom_range(0, 63) == 0) mode = 2'($urandom);
      if ($urandom_range(0, 31) == 0) period = W'($urandom_range(0, 15));
      en = ($urandom_range(0, 9) != 0);
      irq_clr = ($urandom_range(0, 9) == 0);
      if ($urandom_range(0, 2) == 0) tpin = ~tpin;
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule